// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a WIDTH-bit dividend by a WIDTH-bit divisor over several clock cycles and returns both the quotient and the remainder. A single register of 2*WIDTH+1 bits holds all of the working state. Its upper WIDTH+1 bits hold the partial remainder, and quotient bits enter its low end one at a time. One subtractor of WIDTH+2 bits tests a trial subtraction in every iteration. A failed trial keeps the previous upper half, so no separate add-back step is needed.

A caller pulses `start_i` with the operands and the signedness select. `busy_o` stays high while the iterations run. A one-cycle `done_o` pulse marks the cycle in which the results become valid, and the results then stay unchanged until the next completion. In signed mode the block divides the operand magnitudes and sets the result signs afterwards, so the quotient truncates toward zero. A zero divisor completes at once and raises a divide-by-zero flag.

Top module: `seq_divider`

## Requirements
- R1: In unsigned mode the outputs satisfy dividend = quotient*divisor + remainder with remainder < divisor.
- R2: For a nonzero divisor, `busy_o` is high from the cycle after the accepted start until `done_o`. `done_o` is a single-cycle pulse that rises WIDTH+2 cycles after the start edge, and `busy_o` is low while `done_o` is high.
- R3: A `start_i` pulse that arrives while `busy_o` is high is ignored, and the running division completes with its original operands.
- R4: `quotient_o`, `remainder_o` and `div_zero_o` change only in the cycle in which `done_o` is high. Between completions they hold their values whatever the inputs do.
- R5: A zero divisor completes in the cycle after start and never raises `busy_o`. It gives `div_zero_o`=1, a quotient of all ones, and a remainder equal to the dividend bit pattern, in both modes.
- R6: In signed mode (`is_signed_i`=1, two's complement), the quotient magnitude is |dividend| / |divisor| and is negated when the operand signs differ. The remainder takes the sign of the dividend, so for example -7/2 gives -3 remainder -1.
- R7: In signed mode the most negative dividend divided by -1 gives the most negative value as the quotient and zero as the remainder.
- R8: Unsigned operands with the top bit set give exact results, including a divisor of 2^(WIDTH-1) or more.
- R9: After reset `busy_o`, `done_o`, `div_zero_o`, `quotient_o` and `remainder_o` are all 0.
- R10: A completed division with a nonzero divisor clears `div_zero_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only when idle |
| is_signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | WIDTH | Quotient |
| remainder_o | output | WIDTH | Remainder |
| div_zero_o | output | 1 | Last division had a zero divisor |

## Verification
The bench builds the block with WIDTH=8. At that width every sign boundary can be reached with short literal vectors: -128, 127, 255 and divisors at or above 128. This covers the overflow-prone case -128 / -1 and the unsigned cases where a compare based on a sign bit would go wrong. The short iteration count also makes it cheap to check the exact latency, the rejection of a second start in the middle of a division, and the holding of results over many idle cycles.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] num_mag,
    output logic [W-1:0] den_mag,
    output logic         neg_quo,
    output logic         neg_rem
);
    logic num_neg;
    logic den_neg;

    always_comb begin
        num_neg = is_signed & num[W-1];
        den_neg = is_signed & den[W-1];
        num_mag = num_neg ? (~num + 1'b1) : num;
        den_mag = den_neg ? (~den + 1'b1) : den;
        neg_quo = num_neg ^ den_neg;
        neg_rem = num_neg;
    end
endmodule

// File: rtl/div_iter_step.sv
module div_iter_step #(
    parameter int W = 32
) (
    input  logic [W:0]   part_rem,
    input  logic [W-1:0] den,
    output logic [W-1:0] kept_rem,
    output logic         quo_bit
);
    logic [W+1:0] trial;

    always_comb begin
        trial    = {1'b0, part_rem} - {2'b00, den};
        quo_bit  = ~trial[W+1];
        kept_rem = trial[W+1] ? part_rem[W-1:0] : trial[W-1:0];
    end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_raw,
    input  logic [W-1:0] rem_raw,
    input  logic         neg_quo,
    input  logic         neg_rem,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    always_comb begin
        quo = neg_quo ? (~quo_raw + 1'b1) : quo_raw;
        rem = neg_rem ? (~rem_raw + 1'b1) : rem_raw;
    end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             is_signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o,
    output logic             div_zero_o
);
    localparam int ACC_W = 2 * WIDTH + 1;
    localparam int CNT_W = $clog2(WIDTH) + 1;
    localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

    typedef struct packed {
        div_state_e       state;
        logic [CNT_W-1:0] iter;
        logic [ACC_W-1:0] acc;
        logic [WIDTH-1:0] den;
        logic             neg_quo;
        logic             neg_rem;
        logic             busy;
        logic             done;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
        logic             dbz;
    } div_regs_t;

    div_regs_t cur_q, nxt_d;

    logic [WIDTH-1:0] num_mag, den_mag;
    logic             neg_quo_in, neg_rem_in;
    logic [WIDTH-1:0] kept_rem;
    logic             quo_bit;
    logic [WIDTH-1:0] fix_quo, fix_rem;

    div_operand_prep #(.W(WIDTH)) prep_i (
        .is_signed (is_signed_i),
        .num       (dividend_i),
        .den       (divisor_i),
        .num_mag   (num_mag),
        .den_mag   (den_mag),
        .neg_quo   (neg_quo_in),
        .neg_rem   (neg_rem_in)
    );

    div_iter_step #(.W(WIDTH)) step_i (
        .part_rem (cur_q.acc[ACC_W-1:WIDTH]),
        .den      (cur_q.den),
        .kept_rem (kept_rem),
        .quo_bit  (quo_bit)
    );

    div_result_fix #(.W(WIDTH)) fix_i (
        .quo_raw (cur_q.acc[WIDTH-1:0]),
        .rem_raw (cur_q.acc[ACC_W-1:WIDTH+1]),
        .neg_quo (cur_q.neg_quo),
        .neg_rem (cur_q.neg_rem),
        .quo     (fix_quo),
        .rem     (fix_rem)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (divisor_i == '0) begin
                        nxt_d.quo  = '1;
                        nxt_d.rem  = dividend_i;
                        nxt_d.dbz  = 1'b1;
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.acc     = {{WIDTH{1'b0}}, num_mag, 1'b0};
                        nxt_d.den     = den_mag;
                        nxt_d.neg_quo = neg_quo_in;
                        nxt_d.neg_rem = neg_rem_in;
                        nxt_d.iter    = '0;
                        nxt_d.busy    = 1'b1;
                        nxt_d.state   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                nxt_d.acc  = {kept_rem, cur_q.acc[WIDTH-1:0], quo_bit};
                nxt_d.iter = cur_q.iter + 1'b1;
                if (cur_q.iter == LAST_ITER) begin
                    nxt_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                nxt_d.quo   = fix_quo;
                nxt_d.rem   = fix_rem;
                nxt_d.dbz   = 1'b0;
                nxt_d.done  = 1'b1;
                nxt_d.busy  = 1'b0;
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o      = cur_q.busy;
    assign done_o      = cur_q.done;
    assign quotient_o  = cur_q.quo;
    assign remainder_o = cur_q.rem;
    assign div_zero_o  = cur_q.dbz;

endmodule

// File: rtl/seq_divider_checker.sv
module seq_divider_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] quotient_o,
    input logic [WIDTH-1:0] remainder_o,
    input logic             div_zero_o
);
    assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_results_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

    assert_dbz_all_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero_o |-> (quotient_o == {WIDTH{1'b1}}));
endmodule

bind seq_divider seq_divider_checker #(.WIDTH(WIDTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .quotient_o  (quotient_o),
    .remainder_o (remainder_o),
    .div_zero_o  (div_zero_o)
);

// File: tb/seq_divider_tb_top.sv
module seq_divider_tb_top;
    localparam int N = 8;
    localparam int NV = 16;

    // {signed, dividend, divisor, quotient, remainder, dbz}
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 8'd7,   8'd2,   8'd3,   8'd1,   1'b0},
        {1'b0, 8'd100, 8'd7,   8'd14,  8'd2,   1'b0},
        {1'b0, 8'd255, 8'd1,   8'd255, 8'd0,   1'b0},
        {1'b0, 8'd255, 8'd255, 8'd1,   8'd0,   1'b0},
        {1'b0, 8'd200, 8'd201, 8'd0,   8'd200, 1'b0},
        {1'b0, 8'd250, 8'd130, 8'd1,   8'd120, 1'b0},
        {1'b0, 8'd255, 8'd128, 8'd1,   8'd127, 1'b0},
        {1'b1, 8'hF9,  8'd2,   8'hFD,  8'hFF,  1'b0},
        {1'b1, 8'd7,   8'hFE,  8'hFD,  8'd1,   1'b0},
        {1'b1, 8'hF9,  8'hFE,  8'd3,   8'hFF,  1'b0},
        {1'b1, 8'h80,  8'hFF,  8'h80,  8'd0,   1'b0},
        {1'b1, 8'h80,  8'd7,   8'hEE,  8'hFE,  1'b0},
        {1'b0, 8'd0,   8'd5,   8'd0,   8'd0,   1'b0},
        {1'b0, 8'd9,   8'd0,   8'hFF,  8'd9,   1'b1},
        {1'b1, 8'hFB,  8'd0,   8'hFF,  8'hFB,  1'b1},
        {1'b1, 8'd127, 8'h80,  8'd0,   8'd127, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         is_signed_i = 1'b0;
    logic [N-1:0] dividend_i = '0;
    logic [N-1:0] divisor_i = '0;
    logic         busy_o, done_o, div_zero_o;
    logic [N-1:0] quotient_o, remainder_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    seq_divider #(.WIDTH(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .is_signed_i (is_signed_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o),
        .div_zero_o  (div_zero_o)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one division; returns latency in cycles from the start edge.
    task automatic run_div(input logic sg, input logic [N-1:0] a, input logic [N-1:0] b,
                           output int lat, output logic busy_gap);
        @(negedge clk);
        start_i     = 1'b1;
        is_signed_i = sg;
        dividend_i  = a;
        divisor_i   = b;
        lat = 0;
        busy_gap = 1'b0;
        for (int k = 0; k < 4 * N; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            lat++;
            if (done_o) break;
            if (!busy_o) busy_gap = 1'b1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        logic gap;
        logic [N-1:0] hq, hr;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!busy_o && !done_o && !div_zero_o, "R9", {busy_o, done_o, div_zero_o}, 0);
        check(quotient_o == 0 && remainder_o == 0, "R9", {quotient_o, remainder_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run_div(v[33], v[32:25], v[24:17], lat, gap);
            // R1/R6/R7/R8 values, R5 zero divisor, R10 flag clearing
            check(quotient_o == v[16:9], v[33] ? "R6 R7 quotient" : "R1 R8 quotient",
                  quotient_o, v[16:9]);
            check(remainder_o == v[8:1], v[33] ? "R6 R7 remainder" : "R1 R8 remainder",
                  remainder_o, v[8:1]);
            check(div_zero_o == v[0], "R5 R10 div_zero", div_zero_o, v[0]);
            // R2 latency and busy, R5 immediate completion
            check(lat == (v[0] ? 1 : N + 2), v[0] ? "R5 latency" : "R2 latency", lat,
                  v[0] ? 1 : N + 2);
            check(!gap, "R2 busy gap", gap, 0);
        end

        // R1: computed unsigned sweep
        for (int a = 3; a < 256; a += 37) begin
            for (int b = 1; b < 256; b += 51) begin
                run_div(1'b0, N'(a), N'(b), lat, gap);
                check(quotient_o == N'(a / b), "R1 sweep quotient", quotient_o, a / b);
                check(remainder_o == N'(a % b), "R1 sweep remainder", remainder_o, a % b);
            end
        end

        // R3: second start while busy is ignored
        @(negedge clk);
        start_i = 1'b1; is_signed_i = 1'b0; dividend_i = 8'd90; divisor_i = 8'd4;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; dividend_i = 8'd13; divisor_i = 8'd0;
        @(negedge clk);
        start_i = 1'b0;
        check(!done_o && busy_o, "R3 still busy", {done_o, busy_o}, 1);
        for (int k = 0; k < 4 * N && !done_o; k++) @(negedge clk);
        check(quotient_o == 8'd22 && remainder_o == 8'd2 && !div_zero_o, "R3 result",
              {quotient_o, remainder_o}, {8'd22, 8'd2});
        @(negedge clk);
        check(!busy_o && !done_o, "R3 no restart", {busy_o, done_o}, 0);

        // R4: results hold across idle cycles with changing inputs
        hq = quotient_o; hr = remainder_o;
        for (int k = 0; k < 10; k++) begin
            dividend_i = N'(k * 29); divisor_i = N'(k); is_signed_i = k[0];
            @(negedge clk);
        end
        check(quotient_o == hq && remainder_o == hr && !div_zero_o, "R4 hold",
              {quotient_o, remainder_o}, {hq, hr});

        // R5: zero divisor never raises busy
        @(negedge clk);
        start_i = 1'b1; divisor_i = '0; dividend_i = 8'h3C; is_signed_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(!busy_o && done_o && div_zero_o && remainder_o == 8'h3C, "R5 immediate",
              {busy_o, done_o, div_zero_o, remainder_o}, {3'b011, 8'h3C});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule